// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Bit-Error Counter

This block sits on the receive side of a pattern tester. It takes serial NRZ data with a clock that may be gapped and compares each bit against the pattern the transmit side was set up to send. The pattern is either a pseudorandom sequence defined by a two-tap recurrence or a repeating word of 1 to 32 bits. While the block is out of sync, its checker fills itself from the received bits. After a long enough run of bits that fit the pattern, it declares sync. From then on it predicts the stream from its own history and counts every received bit and every bit that differs from the prediction.

A load-count strobe sets the measurement interval. On its rising edge the running bit and error counts are copied into output registers, and the running counts restart from zero in the same cycle. A receive-load strobe copies the 32 most recent raw received bits to an output. Host software divides the two latched counts to get the error ratio. That division and the register interface both sit outside this block.

The configuration has three parts. `pat_len` holds the pattern length minus one: it is n-1 for a pseudorandom sequence of degree n, or N-1 for a repeating word of N bits. `tap_sel` holds m-1 for the second feedback term x^m.

Top module: `rxb_receiver`

## Requirements
- R1: After synchronous reset (rst_n low at a rising clk edge), rlos is 1, bit_count and err_count are 0, and rx_snap is 0.
- R2: In a cycle where rx_dis is 1, nothing is sampled and no receive state changes. rlos, the counts, rx_snap and the checker history all keep their values, and strobe edges are not seen.
- R3: Pseudorandom mode (mode_prbs=1). The expected bit is the bit received pat_len+1 bits earlier XOR the bit received tap_sel+1 bits earlier. Counting from sync_en=1, rlos falls at the edge that samples the (pat_len+35)-th bit in an unbroken run of matching bits, i.e. 34+n bits for degree n.
- R4: Repetitive mode (mode_prbs=0). The expected bit is the bit received pat_len+1 bits earlier. Any word of that period acquires sync under the same run-length rule as R3.
- R5: While in sync, the history shifts in the expected bit, not the received one. Each bit that differs from the prediction therefore counts as exactly one error, and the error does not spread to later predictions.
- R6: Once sync is declared, the bits fall into back-to-back windows of 64 bits. If 6 errors land in one window, rlos rises at the edge that samples the sixth error.
- R7: While resync is 1 in a sampling cycle, rlos is 1 after that edge and the run count is cleared. While sync_en is 0, an out-of-sync checker never declares sync.
- R8: A sampled bit adds to the running counts only if rlos was 0 before that edge. The bit count goes up by 1, and the error count goes up by 1 when the bit is in error.
- R9: A rising edge of (lc_in OR lc_ctl) copies the running counts, including the bit sampled in that same cycle, to bit_count and err_count. The running counts restart at zero in that same edge.
- R10: A rising edge of (rl_in OR rl_ctl) copies the 32 most recent raw received bits to rx_snap. Bit 0 holds the bit sampled in that same cycle, and bit k holds the bit received k samples earlier.
- R11: The running counts stop at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, may be gapped |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Serial NRZ receive data, sampled on rising clk |
| rx_dis | input | 1 | High: skip this edge, freeze all receive state |
| sync_en | input | 1 | Allows sync acquisition |
| resync | input | 1 | Holds the synchronizer out of sync |
| mode_prbs | input | 1 | 1 pseudorandom, 0 repeating word |
| pat_len | input | LEN_W (5) | Pattern length minus one (tap A) |
| tap_sel | input | LEN_W (5) | Second feedback tap minus one (pseudorandom only) |
| lc_in | input | 1 | Load-count strobe pin |
| lc_ctl | input | 1 | Load-count control bit, ORed with lc_in |
| rl_in | input | 1 | Receive-load strobe pin |
| rl_ctl | input | 1 | Receive-load control bit, ORed with rl_in |
| rlos | output | 1 | Loss of sync, active high |
| bit_count | output | CNT_W (32) | Latched bit count |
| err_count | output | CNT_W (32) | Latched error count |
| rx_snap | output | HIST_W (32) | Snapshot of recent raw bits |

## Verification
Three things can land on the same sampled edge as a load-count rising edge: a counted bit, an errored bit, or the edge where sync is declared or lost. If the block handles the copy and clear wrongly, a bit is either lost or counted twice. The bench drives random load-count and receive-load pulses through both the pin and the control-bit inputs, on top of random error injection and gapped sampling. It judges every cycle against a bench model in which the latched value is the old running count plus that edge's contribution. A directed step also fires both strobes together on an errored in-sync bit.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    // Shared widths of the receive checker.
    localparam int unsigned HIST_W_DEF = 32;
    localparam int unsigned CNT_W_DEF  = 32;

    // Pattern families selectable on the receive side.
    typedef enum logic {
        MODE_REPEAT = 1'b0,
        MODE_PRBS   = 1'b1
    } rx_mode_e;
endpackage

// File: rtl/rxb_pattern_check.sv
// Pattern checker: predicts the next bit from a history register.
// The history holds received bits while out of sync (self-seeding) and
// predicted bits while in sync, so a bit error does not spread.
// Assumes len/tap are below HIST_W and stable while the test runs.
module rxb_pattern_check #(
    parameter int unsigned HIST_W = 32,
    localparam int unsigned LEN_W = $clog2(HIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              prbs,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  tap,
    input  logic              rx_bit,
    input  logic              in_sync,
    output logic              err,
    output logic [HIST_W-1:0] raw
);
    logic [HIST_W-1:0] hist;
    logic              expect_bit;

    // Predict the current bit from the tap A and tap B positions.
    always_comb begin
        expect_bit = hist[len] ^ (prbs & hist[tap]);
        err        = rx_bit ^ expect_bit;
    end

    // Shift the prediction history and the raw receive history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            raw  <= '0;
        end else if (en) begin
            hist <= {hist[HIST_W-2:0], (in_sync ? expect_bit : rx_bit)};
            raw  <= {raw[HIST_W-2:0], rx_bit};
        end
    end

    // R5
    sync_follows_prediction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_sync) |=> (hist[0] == $past(expect_bit)));

    // R2
    hist_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(hist) && $stable(raw)));
endmodule

// File: rtl/rxb_sync_fsm.sv
// Synchronizer: counts the unbroken run of matching bits while out of sync
// and declares sync at len+SYNC_BASE. In sync it counts errors over
// back-to-back WIN-bit windows and drops sync when LOSS_ERRS land in one.
// Assumes err is valid whenever en is high.
module rxb_sync_fsm #(
    parameter int unsigned LEN_W     = 5,
    parameter int unsigned SYNC_BASE = 35,
    parameter int unsigned WIN       = 64,
    parameter int unsigned LOSS_ERRS = 6,
    localparam int unsigned MCNT_W   = $clog2((1 << LEN_W) + SYNC_BASE + 1),
    localparam int unsigned WCNT_W   = $clog2(WIN),
    localparam int unsigned WECNT_W  = $clog2(LOSS_ERRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             err,
    input  logic             sync_en,
    input  logic             resync,
    input  logic [LEN_W-1:0] len,
    output logic             in_sync
);
    logic [MCNT_W-1:0]  mcnt;
    logic [MCNT_W-1:0]  thresh;
    logic [WCNT_W-1:0]  wcnt;
    logic [WECNT_W-1:0] wecnt;

    // Run length needed before sync is declared.
    always_comb begin
        thresh = {{(MCNT_W-LEN_W){1'b0}}, len} + MCNT_W'(SYNC_BASE);
    end

    // Acquisition and loss state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync <= 1'b0;
            mcnt    <= '0;
            wcnt    <= '0;
            wecnt   <= '0;
        end else if (en) begin
            if (resync) begin
                in_sync <= 1'b0;
                mcnt    <= '0;
            end else if (!in_sync) begin
                if (!sync_en || err) begin
                    mcnt <= '0;
                end else if (mcnt == thresh - 1'b1) begin
                    in_sync <= 1'b1;
                    mcnt    <= '0;
                    wcnt    <= '0;
                    wecnt   <= '0;
                end else begin
                    mcnt <= mcnt + 1'b1;
                end
            end else if (err && (wecnt == WECNT_W'(LOSS_ERRS - 1))) begin
                in_sync <= 1'b0;
                mcnt    <= '0;
            end else if (wcnt == WCNT_W'(WIN - 1)) begin
                wcnt  <= '0;
                wecnt <= '0;
            end else begin
                wcnt  <= wcnt + 1'b1;
                wecnt <= wecnt + WECNT_W'(err);
            end
        end
    end

    // R7
    resync_forces_los_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && resync) |=> !in_sync);

    // R3
    sync_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> ($past(mcnt) == $past(thresh) - 1'b1));

    // R6
    window_err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wecnt < WECNT_W'(LOSS_ERRS));

    // R2
    sync_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(in_sync) && $stable(mcnt)));
endmodule

// File: rtl/rxb_counters.sv
// Bit and error counters with an atomic load-count snapshot, plus the
// receive-load snapshot of raw bits. Strobes are edge detected on the
// sampled clock; the bit of the strobe cycle is included.
// Assumes in_sync is the state before the current edge.
module rxb_counters #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HIST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_sync,
    input  logic              err,
    input  logic              lc_req,
    input  logic              rl_req,
    input  logic              rx_bit,
    input  logic [HIST_W-1:0] raw,
    output logic [CNT_W-1:0]  bit_q,
    output logic [CNT_W-1:0]  err_q,
    output logic [HIST_W-1:0] snap
);
    localparam int unsigned NCNT = 2;

    logic             lc_prev, rl_prev;
    logic             lc_rise, rl_rise;
    logic [NCNT-1:0]  inc;
    logic [CNT_W-1:0] run  [NCNT];
    logic [CNT_W-1:0] nxt  [NCNT];
    logic [CNT_W-1:0] held [NCNT];

    // Rising-edge detection of the two load strobes.
    always_comb begin
        lc_rise = en & lc_req & ~lc_prev;
        rl_rise = en & rl_req & ~rl_prev;
        inc[0]  = in_sync;
        inc[1]  = in_sync & err;
    end

    // Remember strobe levels on sampled edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_prev <= 1'b0;
            rl_prev <= 1'b0;
        end else if (en) begin
            lc_prev <= lc_req;
            rl_prev <= rl_req;
        end
    end

    // Raw-bit snapshot on a receive-load edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (rl_rise) snap <= {raw[HIST_W-2:0], rx_bit};
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        // Saturating next value of this running counter.
        always_comb begin
            nxt[g] = (&run[g]) ? run[g] : run[g] + CNT_W'(inc[g]);
        end

        // Running count and its latched copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run[g]  <= '0;
                held[g] <= '0;
            end else if (en) begin
                if (lc_rise) begin
                    held[g] <= nxt[g];
                    run[g]  <= '0;
                end else begin
                    run[g]  <= nxt[g];
                end
            end
        end

        // R11
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !lc_rise && (&run[g])) |=> (&run[g]));

        // R8
        count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !in_sync && !lc_rise) |=> $stable(run[g]));

        // R9
        load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lc_rise |=> (run[g] == '0));
    end

    assign bit_q = held[0];
    assign err_q = held[1];
endmodule

// File: rtl/rxb_receiver.sv
// Top of the receive pattern synchronizer and bit-error counter.
// Wires checker, synchronizer and counters; clk is the (gapped) receive
// clock and rx_dis suppresses sampling on an edge.
module rxb_receiver #(
    parameter int unsigned HIST_W    = rxb_pkg::HIST_W_DEF,
    parameter int unsigned CNT_W     = rxb_pkg::CNT_W_DEF,
    parameter int unsigned WIN       = 64,
    parameter int unsigned LOSS_ERRS = 6,
    localparam int unsigned LEN_W    = $clog2(HIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_data,
    input  logic              rx_dis,
    input  logic              sync_en,
    input  logic              resync,
    input  logic              mode_prbs,
    input  logic [LEN_W-1:0]  pat_len,
    input  logic [LEN_W-1:0]  tap_sel,
    input  logic              lc_in,
    input  logic              lc_ctl,
    input  logic              rl_in,
    input  logic              rl_ctl,
    output logic              rlos,
    output logic [CNT_W-1:0]  bit_count,
    output logic [CNT_W-1:0]  err_count,
    output logic [HIST_W-1:0] rx_snap
);
    logic              en;
    logic              err;
    logic              in_sync;
    logic [HIST_W-1:0] raw;

    assign en   = ~rx_dis;
    assign rlos = ~in_sync;

    rxb_pattern_check #(.HIST_W(HIST_W)) u_check (
        .clk(clk), .rst_n(rst_n), .en(en),
        .prbs(mode_prbs == rxb_pkg::MODE_PRBS),
        .len(pat_len), .tap(tap_sel), .rx_bit(rx_data),
        .in_sync(in_sync), .err(err), .raw(raw)
    );

    rxb_sync_fsm #(.LEN_W(LEN_W), .SYNC_BASE(35), .WIN(WIN), .LOSS_ERRS(LOSS_ERRS)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(en), .err(err),
        .sync_en(sync_en), .resync(resync), .len(pat_len), .in_sync(in_sync)
    );

    rxb_counters #(.CNT_W(CNT_W), .HIST_W(HIST_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .in_sync(in_sync), .err(err),
        .lc_req(lc_in | lc_ctl), .rl_req(rl_in | rl_ctl), .rx_bit(rx_data),
        .raw(raw), .bit_q(bit_count), .err_q(err_count), .snap(rx_snap)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rlos && bit_count == '0 && err_count == '0 && rx_snap == '0));
endmodule

// File: tb/tb_rxb_receiver.sv
module tb_rxb_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int SAT_W      = 6;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data = 1'b0, rx_dis = 1'b0, sync_en = 1'b0, resync = 1'b0, mode_prbs = 1'b1;
    logic [4:0] pat_len = 5'd6, tap_sel = 5'd5;
    logic lc_in = 1'b0, lc_ctl = 1'b0, rl_in = 1'b0, rl_ctl = 1'b0;
    logic rlos, rlos_s;
    logic [31:0] bit_count, err_count, rx_snap, snap_s;
    logic [SAT_W-1:0] bit_s, err_s;

    int errors = 0, checks = 0, cyc = 0;
    bit live = 1'b0;
    logic [31:0] gen = 32'h1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxb_receiver dut (
        .clk, .rst_n, .rx_data, .rx_dis, .sync_en, .resync, .mode_prbs,
        .pat_len, .tap_sel, .lc_in, .lc_ctl, .rl_in, .rl_ctl,
        .rlos, .bit_count, .err_count, .rx_snap
    );

    rxb_receiver #(.CNT_W(SAT_W)) dut_sat (
        .clk, .rst_n, .rx_data, .rx_dis, .sync_en, .resync, .mode_prbs,
        .pat_len, .tap_sel, .lc_in, .lc_ctl, .rl_in, .rl_ctl,
        .rlos(rlos_s), .bit_count(bit_s), .err_count(err_s), .rx_snap(snap_s)
    );

    // Bench model state, written from the requirements.
    logic [31:0] m_hist, m_raw, m_snap, m_rb, m_re, m_qb, m_qe;
    logic m_sync, m_lcp, m_rlp;
    int m_mcnt, m_w, m_we;

    function automatic logic [31:0] sat_of(input logic [31:0] v);
        return (v > 32'((1 << SAT_W) - 1)) ? 32'((1 << SAT_W) - 1) : v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model advance on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = 0; m_raw = 0; m_snap = 0; m_rb = 0; m_re = 0; m_qb = 0; m_qe = 0;
            m_sync = 0; m_lcp = 0; m_rlp = 0; m_mcnt = 0; m_w = 0; m_we = 0;
        end else if (!rx_dis) begin
            logic ex, e, lcr, rlr, old_sync;
            logic [31:0] nb, ne;
            ex = m_hist[pat_len] ^ (mode_prbs & m_hist[tap_sel]);
            e = rx_data ^ ex;
            old_sync = m_sync;
            nb = m_rb + {31'd0, old_sync};
            ne = m_re + {31'd0, old_sync & e};
            lcr = (lc_in | lc_ctl) & ~m_lcp;
            rlr = (rl_in | rl_ctl) & ~m_rlp;
            if (lcr) begin m_qb = nb; m_qe = ne; m_rb = 0; m_re = 0; end
            else begin m_rb = nb; m_re = ne; end
            if (rlr) m_snap = {m_raw[30:0], rx_data};
            m_lcp = lc_in | lc_ctl;
            m_rlp = rl_in | rl_ctl;
            m_hist = {m_hist[30:0], old_sync ? ex : rx_data};
            m_raw = {m_raw[30:0], rx_data};
            if (resync) begin m_sync = 0; m_mcnt = 0; end
            else if (!old_sync) begin
                if (!sync_en || e) m_mcnt = 0;
                else if (m_mcnt + 1 == int'(pat_len) + 35) begin
                    m_sync = 1; m_mcnt = 0; m_w = 0; m_we = 0;
                end else m_mcnt++;
            end else if (e && m_we == 5) begin m_sync = 0; m_mcnt = 0; end
            else if (m_w == 63) begin m_w = 0; m_we = 0; end
            else begin m_w++; m_we += int'(e); end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            chk("R3 R4 R6 rlos", {31'd0, rlos}, {31'd0, ~m_sync});
            chk("R8 R9 bit_count", bit_count, m_qb);
            chk("R5 R9 err_count", err_count, m_qe);
            chk("R10 rx_snap", rx_snap, m_snap);
            chk("R11 sat bit_count", {26'd0, bit_s}, sat_of(m_qb));
            chk("R11 sat err_count", {26'd0, err_s}, sat_of(m_qe));
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic gen_bit();
        return gen[pat_len] ^ (mode_prbs & gen[tap_sel]);
    endfunction

    // One bit period: drive data (optionally errored), advance generator if sampled.
    task automatic bit_step(input logic inj);
        logic b;
        b = gen_bit();
        rx_data = b ^ inj;
        @(posedge clk);
        if (!rx_dis) gen = {gen[30:0], b};
        @(negedge clk);
    endtask

    task automatic run_clean(input int n);
        for (int i = 0; i < n; i++) bit_step(1'b0);
    endtask

    task automatic run_random(input int n, input int err_mod);
        for (int i = 0; i < n; i++) begin
            rx_dis = ($urandom % 8) == 0;
            lc_in  = ($urandom % 40) == 0;
            lc_ctl = ($urandom % 60) == 0;
            rl_in  = ($urandom % 40) == 0;
            rl_ctl = ($urandom % 60) == 0;
            bit_step(($urandom % err_mod) == 0);
        end
        rx_dis = 0; lc_in = 0; lc_ctl = 0; rl_in = 0; rl_ctl = 0;
    endtask

    task automatic pulse_lc();
        lc_ctl = 1; bit_step(1'b0); lc_ctl = 0; bit_step(1'b0);
    endtask

    initial begin
        logic [31:0] hold_b, hold_s;
        logic hold_l, last;
        void'($urandom(32'd24681));
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        live = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rlos", {31'd0, rlos}, 32'd1);
        chk("R1 bit_count", bit_count, 32'd0);
        chk("R1 rx_snap", rx_snap, 32'd0);

        // R7: sync_en low prevents acquisition
        run_clean(150);
        chk("R7 sync_en low holds rlos", {31'd0, rlos}, 32'd1);

        // R3: degree-7 sequence acquires sync
        sync_en = 1;
        run_clean(60);
        chk("R3 prbs sync", {31'd0, rlos}, 32'd0);
        pulse_lc();
        pulse_lc();
        chk("R8 bit count after sync", bit_count, 32'd2);
        chk("R5 no errors clean", err_count, 32'd0);

        // R5 R9 R10: strobes together with an errored in-sync bit
        lc_in = 1; rl_in = 1; bit_step(1'b1); last = rx_data;
        lc_in = 0; rl_in = 0;
        chk("R9 error in load cycle", err_count, 32'd1);
        chk("R10 newest snap bit", {31'd0, rx_snap[0]}, {31'd0, last});

        // R2: disabled edges change nothing
        hold_b = bit_count; hold_s = rx_snap; hold_l = rlos;
        rx_dis = 1;
        for (int i = 0; i < 12; i++) begin
            lc_ctl = i[0]; rl_ctl = i[1]; resync = (i == 5);
            bit_step(1'b1);
        end
        rx_dis = 0; lc_ctl = 0; rl_ctl = 0; resync = 0;
        chk("R2 bit_count frozen", bit_count, hold_b);
        chk("R2 rx_snap frozen", rx_snap, hold_s);
        chk("R2 rlos frozen", {31'd0, rlos}, {31'd0, hold_l});

        // Random mixed traffic in pseudorandom mode
        run_random(3000, 70);
        run_clean(120);

        // R6: dense error burst drops sync
        chk("R6 in sync before burst", {31'd0, rlos}, 32'd0);
        for (int i = 0; i < 12; i++) bit_step(1'b1);
        chk("R6 sync lost on burst", {31'd0, rlos}, 32'd1);

        // R7: resync forces loss then reacquire
        run_clean(120);
        resync = 1; bit_step(1'b0); resync = 0;
        chk("R7 resync rlos", {31'd0, rlos}, 32'd1);
        run_clean(120);
        chk("R7 reacquire", {31'd0, rlos}, 32'd0);

        // R4: repetitive 12-bit word
        mode_prbs = 0; pat_len = 5'd11; gen = $urandom;
        resync = 1; bit_step(1'b0); resync = 0;
        run_clean(100);
        chk("R4 repeat sync", {31'd0, rlos}, 32'd0);
        run_random(3000, 90);

        // R3: degree-23 sequence
        mode_prbs = 1; pat_len = 5'd22; tap_sel = 5'd17; gen = 32'h1;
        resync = 1; bit_step(1'b0); resync = 0;
        run_clean(200);
        chk("R3 degree 23 sync", {31'd0, rlos}, 32'd0);
        run_random(2000, 100);

        // R11: long interval saturates narrow counters
        run_clean(100);
        pulse_lc();
        run_clean(300);
        pulse_lc();
        chk("R11 saturated bit count", {26'd0, bit_s}, 32'd63);

        live = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule